// File: doc/BRIEF.md
# Port Input Cell Array

This block sits between 24 device pins, grouped as three 8-bit ports, and the shared input bus of a programmable logic fabric. Every pin has its own input cell. A cell either passes its pin straight through, holds it in a transparent latch, or captures it in an edge-triggered register. Each cell's result drives one bit of the logic input bus, and a processor can read back the cell outputs of one port at a time.

The cells are arranged in groups of four that follow port nibbles. All four cells in a group take their gate from one selectable control source. That source is either the group's own product-term line or the processor address strobe. With the address strobe selected, the cells can hold high-order address bits for the logic fabric for the length of a bus cycle. The product terms arrive as plain inputs, and all configuration is static input wiring.

Everything runs on a single system clock. Control-line edges are found by comparing each group's selected control level with its value at the previous clock edge.

Top module: `port_input_cell_array`

## Requirements
- R1: Pin `k` of port `p` (port A is p=0, port B is p=1, port C is p=2, k from 0 to 7) maps to pin_i and bus_o bit index p*8+k.
- R2: Reset clears the stored value of every cell. After reset, a cell in register mode drives 0 until its first capture.
- R3: Mode code 2'b00 (pass-through) makes the bus bit equal the pin in the same cycle, with no clock delay.
- R4: Mode code 2'b01 (latch) works as follows. While the group's selected control is high, the bus bit follows the pin combinationally. While the control is low, the bus bit holds the pin value sampled at the last clock edge at which the control was high.
- R5: Mode code 2'b10 (register) captures the pin at a clock edge where the selected control is high and was low at the previous edge. At every other edge the cell keeps its value, including while the control stays high.
- R6: Mode code 2'b11 behaves exactly like pass-through.
- R7: Group g covers cells 4g to 4g+3. Source select bit g chooses the group's gate: 0 selects pterm_i[g] and 1 selects strobe_i. A control change in one group leaves cells of every other group unchanged.
- R8: A read select of 0, 1 or 2 puts bus bits 8s+7..8s of the selected port s on rd_data_o in the same cycle.
- R9: A read select of 3 returns 8'h00.
- R10: A change on the control source a group has not selected has no effect on that group's cells.
- R11: Each cell's mode is the 2-bit field at bits 2c+1..2c of mode_cfg_i, where c is the cell index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| pin_i | input | 24 | Pin levels, port A in bits 7..0, port B in 15..8, port C in 23..16 |
| pterm_i | input | 6 | Product-term gate per nibble group |
| strobe_i | input | 1 | Processor address strobe |
| mode_cfg_i | input | 48 | Two mode bits per cell |
| src_cfg_i | input | 6 | Gate source per group: 0 product term, 1 address strobe |
| rd_sel_i | input | 2 | Port selected for processor readback |
| bus_o | output | 24 | Logic input bus, one bit per cell |
| rd_data_o | output | 8 | Readback of the selected port's cell outputs |

## Verification
A corrupt stored value in a latch or register cell appears on its bus bit, and on readback of its port, in the first cycle its gate is low. A stale edge-detect state shows up at the next control rise. In that case a register cell either misses the capture or captures a second time while the control is held high, and the bus diverges one clock after that edge. The stimulus holds each control line high across several edges, gates nibble groups one at a time, and toggles the source a group has not selected, so that each of these faults can be told apart.

// File: rtl/pic_pkg.sv
package pic_pkg;

  typedef enum logic [1:0] {
    MODE_PASS  = 2'b00,
    MODE_LATCH = 2'b01,
    MODE_REG   = 2'b10,
    MODE_RSVD  = 2'b11
  } cell_mode_e;

  typedef enum logic {
    SRC_PTERM  = 1'b0,
    SRC_STROBE = 1'b1
  } gate_src_e;

  localparam int MODE_W = 2;

endpackage

// File: rtl/pic_gate_sel.sv
module pic_gate_sel #(
  parameter int NUM_GROUPS = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_GROUPS-1:0] pterm_i,
  input  logic                  strobe_i,
  input  logic [NUM_GROUPS-1:0] src_i,
  output logic [NUM_GROUPS-1:0] level_o,
  output logic [NUM_GROUPS-1:0] rise_o
);
  import pic_pkg::*;

  logic [NUM_GROUPS-1:0] level_d;
  logic [NUM_GROUPS-1:0] level_q;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    always_comb begin
      if (gate_src_e'(src_i[g]) == SRC_STROBE) level_d[g] = strobe_i;
      else                                     level_d[g] = pterm_i[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_d;
  end

  assign level_o = level_d;
  assign rise_o  = level_d & ~level_q;

endmodule

// File: rtl/pic_cell.sv
module pic_cell (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] mode_i,
  input  logic       level_i,
  input  logic       rise_i,
  output logic       out_o
);
  import pic_pkg::*;

  cell_mode_e mode;
  logic       store_en;
  logic       store_d;
  logic       store_q;

  assign mode = cell_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      MODE_LATCH: store_en = level_i;
      MODE_REG:   store_en = rise_i;
      default:    store_en = 1'b0;
    endcase
    store_d = store_en ? pin_i : store_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) store_q <= 1'b0;
    else        store_q <= store_d;
  end

  always_comb begin
    unique case (mode)
      MODE_LATCH: out_o = level_i ? pin_i : store_q;
      MODE_REG:   out_o = store_q;
      default:    out_o = pin_i;
    endcase
  end

endmodule

// File: rtl/pic_readback.sv
module pic_readback #(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 8,
  parameter int SEL_W     = 2
) (
  input  logic [NUM_PORTS*PORT_W-1:0] bus_i,
  input  logic [SEL_W-1:0]            sel_i,
  output logic [PORT_W-1:0]           data_o
);

  always_comb begin
    data_o = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (sel_i == SEL_W'(p)) data_o = bus_i[p*PORT_W +: PORT_W];
    end
  end

endmodule

// File: rtl/port_input_cell_array.sv
module port_input_cell_array #(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 8,
  parameter int GROUP_W   = 4,
  parameter int SEL_W     = 2,
  localparam int NUM_CELLS  = NUM_PORTS * PORT_W,
  localparam int NUM_GROUPS = NUM_CELLS / GROUP_W,
  localparam int MODE_BITS  = NUM_CELLS * pic_pkg::MODE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CELLS-1:0]  pin_i,
  input  logic [NUM_GROUPS-1:0] pterm_i,
  input  logic                  strobe_i,
  input  logic [MODE_BITS-1:0]  mode_cfg_i,
  input  logic [NUM_GROUPS-1:0] src_cfg_i,
  input  logic [SEL_W-1:0]      rd_sel_i,
  output logic [NUM_CELLS-1:0]  bus_o,
  output logic [PORT_W-1:0]     rd_data_o
);
  import pic_pkg::*;

  logic [1:0]            rst_pipe_q;
  logic                  rst_sync_n;
  logic [NUM_GROUPS-1:0] grp_level;
  logic [NUM_GROUPS-1:0] grp_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  pic_gate_sel #(
    .NUM_GROUPS (NUM_GROUPS)
  ) u_gate_sel (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pterm_i  (pterm_i),
    .strobe_i (strobe_i),
    .src_i    (src_cfg_i),
    .level_o  (grp_level),
    .rise_o   (grp_rise)
  );

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    localparam int GRP = c / GROUP_W;
    pic_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .pin_i   (pin_i[c]),
      .mode_i  (mode_cfg_i[c*MODE_W +: MODE_W]),
      .level_i (grp_level[GRP]),
      .rise_i  (grp_rise[GRP]),
      .out_o   (bus_o[c])
    );
  end

  pic_readback #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W),
    .SEL_W     (SEL_W)
  ) u_readback (
    .bus_i  (bus_o),
    .sel_i  (rd_sel_i),
    .data_o (rd_data_o)
  );

endmodule

// File: rtl/pic_array_checker.sv
module pic_array_checker #(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 8,
  parameter int GROUP_W   = 4,
  parameter int SEL_W     = 2,
  localparam int NUM_CELLS  = NUM_PORTS * PORT_W,
  localparam int NUM_GROUPS = NUM_CELLS / GROUP_W
) (
  input logic                    clk,
  input logic                    rst_sync_n,
  input logic [NUM_CELLS-1:0]    pin_i,
  input logic [NUM_GROUPS-1:0]   pterm_i,
  input logic                    strobe_i,
  input logic [NUM_CELLS*2-1:0]  mode_cfg_i,
  input logic [NUM_GROUPS-1:0]   src_cfg_i,
  input logic [SEL_W-1:0]        rd_sel_i,
  input logic [NUM_CELLS-1:0]    bus_o,
  input logic [PORT_W-1:0]       rd_data_o
);

  logic [NUM_GROUPS-1:0] ctl;
  logic [NUM_GROUPS-1:0] ctl_prev_q;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_ctl
    assign ctl[g] = src_cfg_i[g] ? strobe_i : pterm_i[g];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ctl_prev_q <= '0;
    else             ctl_prev_q <= ctl;
  end

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_chk
    localparam int GRP = c / GROUP_W;
    logic [1:0] m;
    assign m = mode_cfg_i[2*c +: 2];

    assert_pass_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (m == 2'b00) |-> (bus_o[c] == pin_i[c]));

    assert_rsvd_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (m == 2'b11) |-> (bus_o[c] == pin_i[c]));

    assert_latch_open_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (m == 2'b01 && ctl[GRP]) |-> (bus_o[c] == pin_i[c]));

    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (m == 2'b01 && !ctl[GRP]) ##1 (m == 2'b01 && !ctl[GRP]) |-> $stable(bus_o[c]));

    assert_reg_hold_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (m == 2'b10 && !(ctl[GRP] && !ctl_prev_q[GRP])) |=> (m != 2'b10 || $stable(bus_o[c])));

    assert_reg_capture_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (m == 2'b10 && ctl[GRP] && !ctl_prev_q[GRP]) |=> (m != 2'b10 || bus_o[c] == $past(pin_i[c])));
  end

  assert_rd_port_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_sel_i < SEL_W'(NUM_PORTS)) |-> (rd_data_o == bus_o[rd_sel_i*PORT_W +: PORT_W]));

  assert_rd_unused_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_sel_i >= SEL_W'(NUM_PORTS)) |-> (rd_data_o == '0));

endmodule

bind port_input_cell_array pic_array_checker #(
  .NUM_PORTS (NUM_PORTS),
  .PORT_W    (PORT_W),
  .GROUP_W   (GROUP_W),
  .SEL_W     (SEL_W)
) u_pic_array_checker (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .pin_i      (pin_i),
  .pterm_i    (pterm_i),
  .strobe_i   (strobe_i),
  .mode_cfg_i (mode_cfg_i),
  .src_cfg_i  (src_cfg_i),
  .rd_sel_i   (rd_sel_i),
  .bus_o      (bus_o),
  .rd_data_o  (rd_data_o)
);

// File: tb/test_port_input_cell_array.sv
module test_port_input_cell_array;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 24;
  localparam int NG = 6;

  logic          clk;
  logic          rst_n;
  logic [NC-1:0] pin;
  logic [NG-1:0] pterm;
  logic          strobe;
  logic [2*NC-1:0] mode_cfg;
  logic [NG-1:0] src_cfg;
  logic [1:0]    rd_sel;
  logic [NC-1:0] bus;
  logic [7:0]    rd_data;

  port_input_cell_array i_port_input_cell_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (pin),
    .pterm_i    (pterm),
    .strobe_i   (strobe),
    .mode_cfg_i (mode_cfg),
    .src_cfg_i  (src_cfg),
    .rd_sel_i   (rd_sel),
    .bus_o      (bus),
    .rd_data_o  (rd_data)
  );

  typedef struct {
    logic [NC-1:0] exp_bus;
    logic [7:0]    exp_rd;
    string         req;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic          m_store [NC];
  logic [NG-1:0] m_prev;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic sel_ctl(int g);
    return src_cfg[g] ? strobe : pterm[g];
  endfunction

  task automatic model_edge();
    for (int g = 0; g < NG; g++) begin
      logic lv;
      logic rs;
      lv = sel_ctl(g);
      rs = lv & ~m_prev[g];
      for (int c = 4*g; c < 4*g+4; c++) begin
        logic [1:0] m;
        m = mode_cfg[2*c +: 2];
        if ((m == 2'b01 && lv) || (m == 2'b10 && rs)) m_store[c] = pin[c];
      end
      m_prev[g] = lv;
    end
  endtask

  function automatic logic [NC-1:0] exp_bus_f();
    logic [NC-1:0] r;
    for (int c = 0; c < NC; c++) begin
      case (mode_cfg[2*c +: 2])
        2'b01:   r[c] = sel_ctl(c/4) ? pin[c] : m_store[c];
        2'b10:   r[c] = m_store[c];
        default: r[c] = pin[c];
      endcase
    end
    return r;
  endfunction

  task automatic push(string req);
    item_t it;
    it.exp_bus = exp_bus_f();
    it.exp_rd  = (rd_sel < 2'd3) ? it.exp_bus[rd_sel*8 +: 8] : 8'h00;
    it.req     = req;
    q.push_back(it);
  endtask

  // combinational check: inputs were just driven at a negedge
  task automatic check_now(string req);
    #1;
    push(req);
    @(negedge clk);
  endtask

  // clocked check: cross one rising edge, then compare
  task automatic tick(string req);
    @(posedge clk);
    model_edge();
    #1;
    push(req);
    @(negedge clk);
  endtask

  task automatic set_all_modes(logic [1:0] m);
    for (int c = 0; c < NC; c++) mode_cfg[2*c +: 2] = m;
  endtask

  // monitor: pops expected items and compares them with the ports
  initial begin
    item_t it;
    forever begin
      wait (q.size() != 0);
      it = q.pop_front();
      n_cmp++;
      if (bus !== it.exp_bus || rd_data !== it.exp_rd) begin
        n_bad++;
        $display("FAIL %s: bus=%h exp=%h rd=%h exp=%h", it.req, bus, it.exp_bus, rd_data, it.exp_rd);
      end
    end
  end

  initial begin
    #(CLK_PERIOD*5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin = '0; pterm = '0; strobe = 1'b0;
    mode_cfg = '0; src_cfg = '0; rd_sel = 2'd0;
    for (int c = 0; c < NC; c++) m_store[c] = 1'b0;
    m_prev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: reset state, register mode shows cleared storage
    set_all_modes(2'b10); pin = 24'hFFFFFF;
    check_now("R2 reset clears register cells");
    rd_sel = 2'd2; check_now("R2 reset readback port C");

    // R3 / R1 / R8: pass-through and bit mapping
    set_all_modes(2'b00); pin = 24'h000200; rd_sel = 2'd1;
    check_now("R1 pin B1 maps to bus bit 9");
    pin = 24'hA5C33C; rd_sel = 2'd0; check_now("R3 pass-through port A");
    rd_sel = 2'd1; check_now("R8 readback port B");
    rd_sel = 2'd2; check_now("R8 readback port C");
    rd_sel = 2'd3; check_now("R9 unused select reads zero");
    pin = 24'h5A3CC3; rd_sel = 2'd0; tick("R3 pass-through after edge");

    // R11 / R6: per-cell mode fields, reserved code
    set_all_modes(2'b11); pin = 24'h123456;
    check_now("R6 reserved code acts as pass-through");
    mode_cfg[2*3 +: 2] = 2'b10; mode_cfg[2*17 +: 2] = 2'b10;
    pin = 24'hFFFFFF; rd_sel = 2'd2;
    check_now("R11 only cells 3 and 17 in register mode");

    // R4: latch on product terms
    set_all_modes(2'b01); src_cfg = '0; pterm = '1; pin = 24'h0F0F0F; rd_sel = 2'd0;
    check_now("R4 latch transparent");
    tick("R4 latch transparent over edge");
    pin = 24'hF0F0F0; check_now("R4 latch follows pin while open");
    tick("R4 latch samples while open");
    pterm = '0; check_now("R4 latch closes");
    pin = 24'h999999; check_now("R4 latch holds after close");
    tick("R4 latch holds over edge");
    pterm = 6'b000100; check_now("R7 only group 2 latch opens");
    tick("R7 group 2 latch sampled");
    pterm = '0; pin = 24'h000000; tick("R7 group 2 holds new value");

    // R5: register on address strobe
    set_all_modes(2'b10); src_cfg = '1; strobe = 1'b0; pin = 24'h3C3C3C;
    tick("R5 register idle strobe low");
    strobe = 1'b1; tick("R5 register captures on rise");
    pin = 24'hC3C3C3; tick("R5 register ignores held-high strobe");
    tick("R5 register still holds");
    strobe = 1'b0; tick("R5 register strobe falls");
    strobe = 1'b1; tick("R5 register captures second rise");

    // R10: unselected product terms ignored
    strobe = 1'b0; pin = 24'h777777; tick("R10 setup");
    pterm = '1; tick("R10 product term rise ignored");
    pterm = '0; tick("R10 product term fall ignored");
    pterm = '1; rd_sel = 2'd1; tick("R10 readback unchanged");

    // R7: mixed sources per nibble
    pterm = '0; src_cfg = 6'b101010; pin = 24'hABCDEF; tick("R7 mixed setup");
    pterm = 6'b000001; tick("R7 group 0 only captures");
    strobe = 1'b1; rd_sel = 2'd2; tick("R7 strobe groups capture");
    pterm = 6'b010101; pin = 24'h000000; rd_sel = 2'd0; tick("R7 remaining pterm groups capture");

    repeat (2) @(negedge clk);
    wait (q.size() == 0);
    #1;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule